// File: doc/BRIEF.md
# Four-Contestant Quiz Buzzer Controller

This block runs one round of a four-player quiz. The host presses start, a counter shown on an external display steps down from 9 to 0 at one step per second, and only once it has reached 0 may the contestants answer. The first contestant to press after that wins: their lamp lights steadily and the buzzer sounds without a break. Every other key is then locked out until reset.

A contestant who presses while the counter is still running commits a foul. The controller freezes the counter and records that contestant. It then blinks their lamp and pulses the buzzer, toggling both on every 2 Hz tick. Further key presses are ignored until reset.

The block takes one-cycle 1 Hz and 2 Hz enable ticks from an external divider. All inputs are assumed clean and synchronous to the clock. Lamps and buzzer are active low.

Top module: `quiz_buzzer_ctrl`

## Requirements
- R1: While reset is held low on a clock edge, the block goes to idle. In idle, `led_n` is 4'b1111, `buzz_n` is 1 and `count` is 9.
- R2: In idle, a low `start_n` starts the countdown at 9. In the countdown phase, each `tick_1hz` pulse lowers `count` by one.
- R3: The 1 Hz tick that takes `count` from 1 to 0 opens the answer window. While the window is open, `count` stays 0 and all lamps and the buzzer stay off.
- R4: The first press in the open window selects a winner. Contestant k is on key bit k-1 and lamp bit k-1. The winner's lamp goes low and stays low, and `buzz_n` stays low, unaffected by `tick_2hz`.
- R5: If several keys are low in the same cycle while the window is open, the lowest bit index wins.
- R6: After a winner is chosen, other keys, `start_n` and the ticks have no effect on `led_n`, `buzz_n` or `count` until reset.
- R7: A key press during the countdown is a foul. On the next edge, the offender's lamp and `buzz_n` go low. Both then toggle together on each `tick_2hz` pulse, and `count` freezes at its value when the foul occurred.
- R8: When a foul is recorded, the lowest-indexed key pressed in that cycle is taken as the offender. Later presses do not change the offender.
- R9: `start_n` has no effect during the countdown, after a win or after a foul.
- R10: In idle, key presses and ticks have no effect. After reset, a new round starts only when start is pressed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_n | input | 1 | Host start button, active low |
| key_n | input | 4 | Contestant keys, active low; bit k-1 belongs to contestant k |
| tick_1hz | input | 1 | One-cycle enable once per second |
| tick_2hz | input | 1 | One-cycle enable twice per second |
| led_n | output | 4 | Contestant lamps, active low |
| buzz_n | output | 1 | Buzzer, active low |
| count | output | 4 | Countdown value for the display |

## Verification
The assertions assume that the ticks are single-cycle pulses and that keys and start are already debounced and synchronous. They also assume that a press held over several cycles is an ordinary level.

The bench drives each input at the falling edge. It pulses each tick for exactly one cycle, and it holds presses for one or two cycles. No stimulus leaves this envelope.

Multi-key cases are applied in a single cycle, so that the priority checks exercise exactly one edge.

// File: rtl/qb_pkg.sv
// Shared phase encoding for the quiz buzzer controller.
package qb_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_COUNT = 3'd1,
        PH_OPEN  = 3'd2,
        PH_WON   = 3'd3,
        PH_FOUL  = 3'd4
    } qb_phase_t;
endpackage

// File: rtl/qb_countdown.sv
// Countdown register. It reloads to START_VAL on load and steps down by one on dec.
// Assumes dec is never raised while the value is already zero.
module qb_countdown #(
    parameter int CW        = 4,
    parameter int START_VAL = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          dec,
    output logic [CW-1:0] value,
    output logic          at_one
);
    logic [CW-1:0] val_q;

    // Purpose: hold, reload or decrement the displayed count.
    always_ff @(posedge clk) begin
        if (!rst_n || load) val_q <= CW'(START_VAL);
        else if (dec)       val_q <= val_q - 1'b1;
    end

    assign value  = val_q;
    assign at_one = (val_q == CW'(1));

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        val_q <= CW'(START_VAL));
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && val_q != '0) |=> val_q == CW'($past(val_q) - 1'b1));
endmodule

// File: rtl/qb_arbiter.sv
// Fixed-priority picker over active-low keys. The lowest index wins.
// Purely combinational. Keys are assumed clean and synchronous.
module qb_arbiter #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  key_n,
    output logic          any,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx
);
    logic [N-1:0] req;
    logic [N:0]   lower_seen;

    assign req           = ~key_n;
    assign lower_seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_pri
            assign grant[g]        = req[g] & ~lower_seen[g];
            assign lower_seen[g+1] = lower_seen[g] | req[g];
        end
    endgenerate

    assign any = lower_seen[N];

    // Purpose: encode the one-hot grant as a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++)
            if (grant[i]) idx = IW'(i);
    end

    always_comb begin
        assert_grant_onehot_R5: assert ($onehot0(grant));
    end
endmodule

// File: rtl/qb_indicator.sv
// Drives the active-low lamps and buzzer from the phase and the latched contestant.
// In a win the lamp and buzzer are steady. In a foul they toggle on each 2 Hz tick.
module qb_indicator
    import qb_pkg::*;
#(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  qb_phase_t     phase,
    input  logic [IW-1:0] sel,
    input  logic          tick_2hz,
    output logic [N-1:0]  led_n,
    output logic          buzz_n
);
    logic blink_q;
    logic active;

    // Purpose: blink phase, 1 (on) on foul entry, toggled by 2 Hz ticks in foul.
    always_ff @(posedge clk) begin
        if (!rst_n || phase != PH_FOUL) blink_q <= 1'b1;
        else if (tick_2hz)              blink_q <= ~blink_q;
    end

    // Purpose: decide whether the indication is currently on.
    always_comb begin
        active = (phase == PH_WON) || (phase == PH_FOUL && blink_q);
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_led
            assign led_n[g] = ~(active && sel == IW'(g));
        end
    endgenerate

    assign buzz_n = ~active;

    assert_one_lamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~led_n));
    assert_won_buzz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_WON |-> !buzz_n);
    assert_foul_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FOUL && tick_2hz) |=> (phase != PH_FOUL || buzz_n != $past(buzz_n)));
endmodule

// File: rtl/quiz_buzzer_ctrl.sv
// Four-contestant quiz buzzer controller: host start, 9-to-0 countdown, answer window,
// winner lockout and early-press foul. Assumes clean synchronous inputs and
// single-cycle 1 Hz / 2 Hz enable ticks.
module quiz_buzzer_ctrl
    import qb_pkg::*;
#(
    parameter int N         = 4,
    parameter int CW        = 4,
    parameter int START_VAL = 9,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_n,
    input  logic [N-1:0]  key_n,
    input  logic          tick_1hz,
    input  logic          tick_2hz,
    output logic [N-1:0]  led_n,
    output logic          buzz_n,
    output logic [CW-1:0] count
);
    qb_phase_t     phase_q, phase_d;
    logic [IW-1:0] sel_q;
    logic          key_any;
    logic [N-1:0]  key_grant;
    logic [IW-1:0] key_idx;
    logic          cd_one;
    logic          cd_load;
    logic          cd_dec;

    qb_arbiter #(.N(N)) u_arb (
        .key_n (key_n),
        .any   (key_any),
        .grant (key_grant),
        .idx   (key_idx)
    );

    qb_countdown #(.CW(CW), .START_VAL(START_VAL)) u_cd (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cd_load),
        .dec    (cd_dec),
        .value  (count),
        .at_one (cd_one)
    );

    qb_indicator #(.N(N)) u_ind (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase_q),
        .sel      (sel_q),
        .tick_2hz (tick_2hz),
        .led_n    (led_n),
        .buzz_n   (buzz_n)
    );

    // Purpose: next-phase decision for one round.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  if (!start_n) phase_d = PH_COUNT;
            PH_COUNT: if (key_any) phase_d = PH_FOUL;
                      else if (tick_1hz && cd_one) phase_d = PH_OPEN;
            PH_OPEN:  if (key_any) phase_d = PH_WON;
            default:  phase_d = phase_q;
        endcase
    end

    // Purpose: countdown controls derived from the phase.
    always_comb begin
        cd_load = (phase_q == PH_IDLE);
        cd_dec  = (phase_q == PH_COUNT) && tick_1hz && !key_any;
    end

    // Purpose: register the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Purpose: latch the winner or offender on entry to a terminal phase.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else if ((phase_q == PH_COUNT || phase_q == PH_OPEN) && key_any)
            sel_q <= key_idx;
    end

    assert_open_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_OPEN |-> count == '0);
    assert_idle_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_IDLE |-> (led_n == '1 && buzz_n && count == CW'(START_VAL)));
    assert_winner_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_WON |=> ($stable(sel_q) && $stable(count) && phase_q == PH_WON));
    assert_offender_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_FOUL |=> ($stable(sel_q) && $stable(count) && phase_q == PH_FOUL));
endmodule

// File: tb/quiz_buzzer_ctrl_tb.sv
module quiz_buzzer_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_n = 1'b1;
    logic [3:0] key_n = 4'hF;
    logic       tick_1hz = 1'b0;
    logic       tick_2hz = 1'b0;
    logic [3:0] led_n;
    logic       buzz_n;
    logic [3:0] count;
    int         n_run = 0;
    int         n_fail = 0;

    quiz_buzzer_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .key_n(key_n),
        .tick_1hz(tick_1hz), .tick_2hz(tick_2hz),
        .led_n(led_n), .buzz_n(buzz_n), .count(count)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [3:0] l, input logic b, input logic [3:0] c);
        n_run++;
        if (led_n !== l || buzz_n !== b || count !== c) begin
            n_fail++;
            $display("FAIL %s: led_n=%b buzz_n=%b count=%0d, expected led_n=%b buzz_n=%b count=%0d",
                     tag, led_n, buzz_n, count, l, b, c);
        end
    endtask

    task automatic cyc(); @(negedge clk); endtask
    task automatic do_reset(); rst_n = 0; cyc(); cyc(); rst_n = 1; cyc(); endtask
    task automatic pulse_1hz(); tick_1hz = 1; cyc(); tick_1hz = 0; cyc(); endtask
    task automatic pulse_2hz(); tick_2hz = 1; cyc(); tick_2hz = 0; cyc(); endtask
    task automatic press(input logic [3:0] k); key_n = k; cyc(); key_n = 4'hF; cyc(); endtask
    task automatic push_start(); start_n = 0; cyc(); start_n = 1; cyc(); endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset state", 4'hF, 1'b1, 4'd9);
    endtask

    task automatic t_idle_ignore();
        do_reset();
        pulse_1hz();
        press(4'b1110);
        pulse_2hz();
        chk("R10 idle ignores keys and ticks", 4'hF, 1'b1, 4'd9);
    endtask

    task automatic t_win();
        do_reset();
        push_start();
        chk("R2 countdown starts at 9", 4'hF, 1'b1, 4'd9);
        pulse_1hz();
        chk("R2 first tick", 4'hF, 1'b1, 4'd8);
        push_start();
        chk("R9 start ignored in countdown", 4'hF, 1'b1, 4'd8);
        for (int i = 0; i < 7; i++) pulse_1hz();
        chk("R2 count at 1", 4'hF, 1'b1, 4'd1);
        pulse_1hz();
        chk("R3 window open at 0", 4'hF, 1'b1, 4'd0);
        press(4'b1011);
        chk("R4 contestant 3 wins", 4'b1011, 1'b0, 4'd0);
        press(4'b0111);
        chk("R6 later key locked out", 4'b1011, 1'b0, 4'd0);
        push_start();
        pulse_1hz();
        chk("R9 start ignored after win", 4'b1011, 1'b0, 4'd0);
        pulse_2hz();
        chk("R4 steady under 2 Hz tick", 4'b1011, 1'b0, 4'd0);
    endtask

    task automatic t_simul_win();
        do_reset();
        push_start();
        for (int i = 0; i < 9; i++) pulse_1hz();
        press(4'b0101);
        chk("R5 keys 2 and 4 together, 2 wins", 4'b1101, 1'b0, 4'd0);
    endtask

    task automatic t_foul();
        do_reset();
        push_start();
        for (int i = 0; i < 3; i++) pulse_1hz();
        press(4'b1110);
        chk("R7 foul by contestant 1", 4'b1110, 1'b0, 4'd6);
        pulse_2hz();
        chk("R7 blink off", 4'hF, 1'b1, 4'd6);
        pulse_2hz();
        chk("R7 blink on", 4'b1110, 1'b0, 4'd6);
        press(4'b1101);
        chk("R8 offender unchanged", 4'b1110, 1'b0, 4'd6);
        pulse_1hz();
        push_start();
        chk("R9 start and 1 Hz ignored in foul", 4'b1110, 1'b0, 4'd6);
    endtask

    task automatic t_foul_multi();
        do_reset();
        push_start();
        press(4'b0011);
        chk("R8 keys 3 and 4 early, 3 offends", 4'b1011, 1'b0, 4'd9);
    endtask

    task automatic t_restart();
        do_reset();
        pulse_1hz();
        chk("R10 no round without start", 4'hF, 1'b1, 4'd9);
        push_start();
        pulse_1hz();
        chk("R10 new round counts", 4'hF, 1'b1, 4'd8);
    endtask

    initial begin
        cyc();
        t_reset();
        t_idle_ignore();
        t_win();
        t_simul_win();
        t_foul();
        t_foul_multi();
        t_restart();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule